// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs an 8-bit successive-approximation search for a converter whose analog parts live outside it. A host starts a conversion through two active-low strobes, a chip select and a write strobe, both treated as asynchronous and brought into the clock domain by a two-flop synchronizer. While both strobes are low the sequencer is parked in a cleared state. Releasing either strobe arms a start that waits for the next wrap of a divide-by-8 phase counter. The search then begins with the top bit.

Each bit gets an eight-clock window. The trial code on `trial_o` drives an external DAC, and the comparator answer on `cmp_i` is sampled at the end of the window to keep or drop that bit. A one-hot marker register walks from the top bit to the bottom bit. When the marker falls off the last stage, the search is over. One clock later a single-cycle `done_o` pulse presents the result on `code_o`.

Tying the write strobe to the inverted done pulse with chip select held low makes the block convert continuously.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After `rst_ni` is released, `trial_o`, `code_o`, `busy_o` and `done_o` are all zero.
- R2: While `cs_ni` and `wr_ni` are both low, after the two-clock synchronizer delay, `trial_o` is 0x00, `busy_o` is low and `done_o` stays low.
- R3: The first rising clock edge after the strobes stop both being low counts as edge 1. Counted that way, `busy_o` goes high after edge 3 to edge 10. The start is aligned to the next wrap of an 8-clock phase counter. Release by `cs_ni` alone works as well as release by `wr_ni` alone.
- R4: The first trial code after the start is 0x80 (the MSB set). `trial_o` then holds for exactly 8 clocks before it changes.
- R5: At the end of each bit window, the bit under test is kept when `cmp_i` is 1 (input at or above the trial value) and cleared when it is 0. The next lower bit is then set. The search therefore ends with the largest code not exceeding the input.
- R6: `done_o` rises exactly 65 clocks after `busy_o` rises, which is 68 to 75 edges after release. It lasts one cycle, with `code_o` equal to the final code.
- R7: An input at or below zero gives code 0x00. An input at or above full scale gives 0xFF.
- R8: Driving both strobes low during a conversion aborts it. `busy_o` and `trial_o` clear, and no `done_o` follows.
- R9: With `cs_ni` low and `wr_ni` driven by the inverse of `done_o`, conversions repeat back to back, and each one produces a correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| wr_ni | input | 1 | Write/start strobe, active low, asynchronous |
| cmp_i | input | 1 | Comparator result: 1 when input is at or above the trial value |
| trial_o | output | 8 | Trial code to the external DAC |
| busy_o | output | 1 | High while the bit search runs |
| done_o | output | 1 | One-cycle completion pulse |
| code_o | output | 8 | Final code, valid while `done_o` is high |

## Verification
The checker watches several rules on every cycle:
- the parked state while the synchronized strobes are both low;
- the MSB-first trial after a start;
- `trial_o` being steady between bit steps;
- the marker staying one-hot;
- the keep-or-clear decision against `cmp_i`;
- a one-cycle `done_o` that carries the current trial.

Only the bench scenarios can show the following:
- the 3-to-10 edge start latency and the 68-to-75 edge total seen from the pins;
- correct final codes across inputs below zero, inside the range and above full scale;
- start by chip select;
- the missing result after an abort;
- chained free-running conversions.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int unsigned CODE_W_DEF = 8;
  localparam int unsigned STEP_LEN_DEF = 8;
  localparam int unsigned SYNC_LEN_DEF = 2;

  typedef enum logic [1:0] {
    SRCH_IDLE = 2'd0,
    SRCH_RUN  = 2'd1,
    SRCH_FIN  = 2'd2
  } srch_state_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int unsigned N      = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [STAGES-1:0][N-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sar_start_ctrl.sv
module sar_start_ctrl #(
  parameter int unsigned STEP_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_s_ni,
  input  logic wr_s_ni,
  output logic hold_o,
  output logic step_o,
  output logic go_o
);
  localparam int unsigned PH_W = (STEP_LEN > 2) ? $clog2(STEP_LEN) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(STEP_LEN - 1);

  logic [PH_W-1:0] phase_q;
  logic            start_q;

  assign hold_o = ~cs_s_ni & ~wr_s_ni;
  assign step_o = (phase_q == PH_LAST);
  // start fires on the phase wrap after release
  assign go_o   = start_q & ~hold_o & step_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (step_o) phase_q <= '0;
    else             phase_q <= phase_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     start_q <= 1'b0;
    else if (hold_o) start_q <= 1'b1;
    else if (step_o) start_q <= 1'b0;
  end
endmodule

// File: rtl/sar_search.sv
module sar_search
  import sar_seq_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic         step_i,
  input  logic         go_i,
  input  logic         cmp_i,
  output logic [W-1:0] trial_o,
  output logic [W-1:0] mark_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] code_o
);
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  srch_state_e  state_q;
  logic [W-1:0] sar_q, mark_q, code_q;
  logic         done_q;
  logic [W-1:0] decided;

  assign decided = cmp_i ? sar_q : (sar_q & ~mark_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SRCH_IDLE;
      sar_q   <= '0;
      mark_q  <= '0;
      code_q  <= '0;
      done_q  <= 1'b0;
    end else if (hold_i) begin
      state_q <= SRCH_IDLE;
      sar_q   <= '0;
      mark_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SRCH_IDLE: if (go_i) begin
          sar_q   <= TOP_BIT;
          mark_q  <= TOP_BIT;
          state_q <= SRCH_RUN;
        end
        SRCH_RUN: if (step_i) begin
          sar_q  <= decided | (mark_q >> 1);
          mark_q <= mark_q >> 1;
          if (mark_q[0]) state_q <= SRCH_FIN;
        end
        SRCH_FIN: begin
          code_q  <= sar_q;
          done_q  <= 1'b1;
          state_q <= SRCH_IDLE;
        end
        default: state_q <= SRCH_IDLE;
      endcase
    end
  end

  assign trial_o = sar_q;
  assign mark_o  = mark_q;
  assign busy_o  = (state_q == SRCH_RUN);
  assign done_o  = done_q;
  assign code_o  = code_q;
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int unsigned W        = CODE_W_DEF,
  parameter int unsigned STEP_LEN = STEP_LEN_DEF,
  parameter int unsigned SYNC_LEN = SYNC_LEN_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_ni,
  input  logic         wr_ni,
  input  logic         cmp_i,
  output logic [W-1:0] trial_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] code_o
);
  logic [1:0]   strb_s;
  logic         hold, step, go;
  logic [W-1:0] mark;

  sar_sync #(.N(2), .STAGES(SYNC_LEN), .RST_VAL(2'b11)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, wr_ni}),
    .q_o   (strb_s)
  );

  sar_start_ctrl #(.STEP_LEN(STEP_LEN)) i_start (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_s_ni(strb_s[1]),
    .wr_s_ni(strb_s[0]),
    .hold_o (hold),
    .step_o (step),
    .go_o   (go)
  );

  sar_search #(.W(W)) i_search (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .step_i (step),
    .go_i   (go),
    .cmp_i  (cmp_i),
    .trial_o(trial_o),
    .mark_o (mark),
    .busy_o (busy_o),
    .done_o (done_o),
    .code_o (code_o)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         hold_i,
  input logic         step_i,
  input logic         go_i,
  input logic         cmp_i,
  input logic [W-1:0] mark_i,
  input logic [W-1:0] trial_i,
  input logic         busy_i,
  input logic         done_i,
  input logic [W-1:0] code_i
);
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  p_hold_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (!busy_i && trial_i == '0 && !done_i));

  p_msb_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |=> (busy_i && trial_i == TOP_BIT));

  p_steady_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !step_i && !hold_i) |=> $stable(trial_i));

  p_marker_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mark_i));

  p_keep_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && step_i && !hold_i && cmp_i) |=> ((trial_i & $past(mark_i)) != '0));

  p_drop_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && step_i && !hold_i && !cmp_i) |=> ((trial_i & $past(mark_i)) == '0));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_done_code_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (code_i == trial_i && !busy_i));
endmodule

bind sar_seq_ctrl sar_seq_chk #(.W(W)) i_sar_seq_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .hold_i (hold),
  .step_i (step),
  .go_i   (go),
  .cmp_i  (cmp_i),
  .mark_i (mark),
  .trial_i(trial_o),
  .busy_i (busy_o),
  .done_i (done_o),
  .code_i (code_o)
);

// File: tb/test_sar_seq_ctrl.sv
module test_sar_seq_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam realtime TCLK = 5.0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       wr_drv = 1'b1;
  logic       free_run = 1'b0;
  logic       wr_n;
  logic       cmp;
  logic [7:0] trial, code;
  logic       busy, done;
  int         vin = 0;

  int n_chk = 0;
  int n_err = 0;
  int done_seen = 0;
  int exp_q[$];

  always #(TCLK / 2) clk = ~clk;

  assign wr_n = free_run ? ~done : wr_drv;
  assign cmp  = (vin >= int'(trial));

  sar_seq_ctrl i_sar_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n), .cmp_i(cmp),
    .trial_o(trial), .busy_o(busy), .done_o(done), .code_o(code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int clamp(input int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      done_seen++;
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected done", int'(code), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(code) == e, "R5/R7 code", int'(code), e);
      end
    end
  end

  task automatic park(input int cycles);
    @(negedge clk);
    free_run = 1'b0;
    cs_n = 1'b0;
    wr_drv = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic convert(input int v, input bit by_cs);
    int n, m, k;
    vin = v;
    park(4);
    chk(!busy && trial == 8'h00 && !done, "R2 parked", int'(trial), 0);
    exp_q.push_back(clamp(v));
    if (by_cs) cs_n = 1'b1;
    else       wr_drv = 1'b1;
    n = 0;
    while (1) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (busy || n > 20) break;
    end
    chk(n >= 3 && n <= 10, "R3 start latency", n, 3);
    chk(trial == 8'h80, "R4 first trial", int'(trial), 128);
    m = 0;
    while (1) begin
      @(posedge clk); m++;
      @(negedge clk);
      if (trial != 8'h80 || m > 20) break;
    end
    chk(m == 8, "R4 bit window", m, 8);
    k = 0;
    while (1) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (done || k > 100) break;
    end
    chk(m + k == 65, "R6 busy-to-done", m + k, 65);
    chk(n + m + k >= 68 && n + m + k <= 75, "R6 total", n + m + k, 68);
    @(negedge clk);
    chk(!done, "R6 single pulse", int'(done), 0);
  endtask

  initial begin
    #(TCLK * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    // R1
    chk(trial == 0 && code == 0 && !busy && !done, "R1 reset state", int'(trial), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(trial == 0 && code == 0 && !busy && !done, "R1 after reset", int'(code), 0);

    // R5 mid-scale patterns, R7 boundaries, R3 start by cs
    convert(8'h5A, 1'b0);
    convert(128, 1'b0);
    convert(127, 1'b1);
    convert(1, 1'b0);
    convert(-3, 1'b0);
    convert(0, 1'b1);
    convert(255, 1'b0);
    convert(400, 1'b0);
    convert(8'hA5, 1'b1);

    // R2 long hold
    park(40);
    chk(!busy && trial == 0, "R2 long hold", int'(busy), 0);

    // R8 abort mid-conversion
    vin = 200;
    wr_drv = 1'b1;
    repeat (30) @(negedge clk);
    chk(busy, "R8 running before abort", int'(busy), 1);
    d0 = done_seen;
    cs_n = 1'b0;
    wr_drv = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && trial == 0, "R8 aborted", int'(trial), 0);
    repeat (100) @(negedge clk);
    chk(done_seen == d0, "R8 no result", done_seen, d0);

    // R9 free running
    vin = 8'hC3;
    d0 = done_seen;
    repeat (3) exp_q.push_back(8'hC3);
    free_run = 1'b1;
    for (int i = 0; i < 300 && done_seen < d0 + 3; i++) @(negedge clk);
    chk(done_seen == d0 + 3, "R9 three chained results", done_seen - d0, 3);
    free_run = 1'b0;
    wr_drv = 1'b0;
    repeat (100) @(negedge clk);
    chk(done_seen == d0 + 3 && exp_q.size() == 0, "R9 stop", done_seen - d0, 3);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule